// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 interface. Once a status input reports that the supplies are good, it walks the memory through its mandatory bring-up script. It first holds the clock enable low for a stable-clock interval. It then raises the clock enable while driving no-operation cycles. After that it issues a fixed, ordered run of precharge-all, extended mode register writes, mode register writes and auto-refresh commands. Each wait is timed in clock cycles.

Every interval is a parameter in cycles. The two long waits default to values derived from a clock-period parameter. Mode register contents come from parameters. The sequencer forces only the bits that the bring-up script itself dictates: DLL enable, DLL reset and clear, OCD default and exit, and the high address bit. When the last OCD-exit write has settled, a ready flag rises and stays high, and the command bus idles on no-operation. A synchronous reset starts the whole script over.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is applied, and while `pwr_ok` is low afterwards, the block holds `cke`=0 and `done`=0 and drives a deselect, {cs_n,ras_n,cas_n,we_n}=1111.
- R2: `cke` rises exactly STABLE_CYC cycles after the first clock edge that samples `pwr_ok` high. It then stays high until reset. Before it rises, the bus carries only deselect.
- R3: After `cke` rises, exactly CKE_NOP_CYC cycles of no-operation (0111) pass before the first command, which is precharge-all (0010 with addr[10]=1).
- R4: The commands, in order, are: precharge-all, write to EMR2, write to EMR3, DLL-enable write to EMR1, DLL-reset write to MR, precharge-all, auto-refresh (0001), auto-refresh, operating write to MR, OCD-default write to EMR1, OCD-exit write to EMR1. Mode writes use code 0000.
- R5: Mode writes select their register on ba[2:0]: MR=000, EMR1=001, EMR2=010, EMR3=011. The EMR2 and EMR3 writes carry their parameter values unchanged.
- R6: The DLL-enable EMR1 write carries EMR1_OPS with addr bits 13, 9, 8, 7 and 0 forced to 0.
- R7: The first MR write carries MR_OPS with addr[13]=0 and addr[8]=1, which resets the DLL. The later MR write carries the same value with addr[8]=0.
- R8: Exactly one command is issued per cycle, and no-operation fills every other cycle. The next command follows exactly TMRD_CYC cycles after a mode write, TRP_CYC cycles after a precharge and TRFC_CYC cycles after an auto-refresh.
- R9: The OCD-default write is issued at the later of two times: TMRD_CYC cycles after the operating MR write, or DLL_LOCK_CYC cycles after the DLL-reset write. It carries the DLL-enable value with addr[9:7]=111. The OCD-exit write follows with the same value and addr[9:7]=000.
- R10: `done` rises exactly TMRD_CYC cycles after the OCD-exit write. It stays high, and only no-operation with `cke`=1 follows.
- R11: Reset applied mid-sequence returns the block to the R1 state at the next edge. A later `pwr_ok` replays the full sequence.
- R12: `odt` is low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supplies stable; starts the script |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address / mode register select |
| addr | output | 14 | Address / mode register contents |
| done | output | 1 | Device ready for normal operation |

## Verification
The bench builds the sequencer with a 20-cycle stable-clock wait, a 5-cycle CKE-to-command wait, mode/precharge/refresh gaps of 2, 3 and 7 cycles, and a 30-cycle DLL lock wait. With these values the full script runs in under 70 cycles. The lock wait, rather than the command gaps, sets the time of the OCD-default write, so both arms of that rule are reached. The mode register parameters have the forced bits (13, 9, 8, 7, 0) set, so every forced clear and set can be seen at the address pins. The script runs to completion, is cut off by a mid-sequence reset, and is then replayed in full. The expected time and content of every command are derived from the parameters.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;

    // address bit positions the bring-up script controls
    localparam int BIT_DLL_OFF  = 0;
    localparam int BIT_OCD_LO   = 7;
    localparam int BIT_DLL_RST  = 8;
    localparam int BIT_OCD_HI   = 9;
    localparam int BIT_ALL_BANK = 10;
    localparam int BIT_TOP      = 13;

    typedef enum logic [3:0] {
        CMD_MODE      = 4'b0000,
        CMD_REFRESH   = 4'b0001,
        CMD_PRECHARGE = 4'b0010,
        CMD_NOP       = 4'b0111,
        CMD_DESELECT  = 4'b1111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PREA_FIRST,
        ST_EXT2,
        ST_EXT3,
        ST_EXT1_DLL_ON,
        ST_MAIN_DLL_RST,
        ST_PREA_SECOND,
        ST_REFRESH_A,
        ST_REFRESH_B,
        ST_MAIN_OPER,
        ST_EXT1_OCD_DEF,
        ST_EXT1_OCD_EXIT
    } step_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLK_STABLE,
        PH_CKE_WAIT,
        PH_ISSUE,
        PH_GAP,
        PH_READY
    } phase_e;

    typedef enum logic [1:0] {
        GAP_MODE,
        GAP_PRECH,
        GAP_REFR
    } gap_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } bus_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/ddr2i_wait_timer.sv
module ddr2i_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R8: an expired timer stays expired until it is reloaded
    a_r8_timer_parks: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/ddr2i_step_decode.sv
module ddr2i_step_decode
    import ddr2i_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MR_OPS   = '0,
    parameter logic [ADDR_W-1:0] EMR1_OPS = '0,
    parameter logic [ADDR_W-1:0] EMR2_VAL = '0,
    parameter logic [ADDR_W-1:0] EMR3_VAL = '0
) (
    input  step_e step,
    output bus_t  bus,
    output gap_e  gap_kind
);
    localparam logic [ADDR_W-1:0] M_TOP   = ADDR_W'(1) << BIT_TOP;
    localparam logic [ADDR_W-1:0] M_DLLR  = ADDR_W'(1) << BIT_DLL_RST;
    localparam logic [ADDR_W-1:0] M_DLLO  = ADDR_W'(1) << BIT_DLL_OFF;
    localparam logic [ADDR_W-1:0] M_OCD   = (ADDR_W'(1) << BIT_OCD_HI)
                                          | (ADDR_W'(1) << BIT_DLL_RST)
                                          | (ADDR_W'(1) << BIT_OCD_LO);
    localparam logic [ADDR_W-1:0] M_ALLBK = ADDR_W'(1) << BIT_ALL_BANK;

    localparam logic [ADDR_W-1:0] MR_BASE  = MR_OPS & ~(M_TOP | M_DLLR);
    localparam logic [ADDR_W-1:0] EMR1_BASE = EMR1_OPS & ~(M_TOP | M_OCD | M_DLLO);

    always_comb begin
        bus.cmd  = CMD_MODE;
        bus.bank = '0;
        bus.addr = '0;
        gap_kind = GAP_MODE;
        case (step)
            ST_PREA_FIRST, ST_PREA_SECOND: begin
                bus.cmd  = CMD_PRECHARGE;
                bus.addr = M_ALLBK;
                gap_kind = GAP_PRECH;
            end
            ST_EXT2: begin
                bus.bank = 3'b010;
                bus.addr = EMR2_VAL;
            end
            ST_EXT3: begin
                bus.bank = 3'b011;
                bus.addr = EMR3_VAL;
            end
            ST_EXT1_DLL_ON, ST_EXT1_OCD_EXIT: begin
                bus.bank = 3'b001;
                bus.addr = EMR1_BASE;
            end
            ST_EXT1_OCD_DEF: begin
                bus.bank = 3'b001;
                bus.addr = EMR1_BASE | M_OCD;
            end
            ST_MAIN_DLL_RST: bus.addr = MR_BASE | M_DLLR;
            ST_MAIN_OPER:    bus.addr = MR_BASE;
            ST_REFRESH_A, ST_REFRESH_B: begin
                bus.cmd  = CMD_REFRESH;
                gap_kind = GAP_REFR;
            end
            default: bus.cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int CLK_PS       = 2500,
    parameter int STABLE_CYC   = ceil_div(200_000_000, CLK_PS),
    parameter int CKE_NOP_CYC  = ceil_div(400_000, CLK_PS),
    parameter int TMRD_CYC     = 2,
    parameter int TRP_CYC      = ceil_div(15_000, CLK_PS) + 1,
    parameter int TRFC_CYC     = ceil_div(127_500, CLK_PS) + 1,
    parameter int DLL_LOCK_CYC = 200,
    parameter logic [13:0] MR_OPS   = 14'h0432,
    parameter logic [13:0] EMR1_OPS = 14'h0004,
    parameter logic [13:0] EMR2_VAL = 14'h0000,
    parameter logic [13:0] EMR3_VAL = 14'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_ok,
    output logic        cke,
    output logic        odt,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [2:0]  ba,
    output logic [13:0] addr,
    output logic        done
);
    localparam int GMAX = max2(max2(STABLE_CYC, CKE_NOP_CYC),
                               max2(TMRD_CYC, max2(TRP_CYC, TRFC_CYC)));
    localparam int GW   = $clog2(GMAX + 1);
    localparam int LW   = $clog2(DLL_LOCK_CYC + 1);

    phase_e phase_q;
    step_e  step_q;
    bus_t   step_bus;
    gap_e   gap_kind;
    logic   gap_load, gap_zero, lock_load, lock_zero;
    logic [GW-1:0] gap_val;

    ddr2i_step_decode #(
        .MR_OPS(MR_OPS), .EMR1_OPS(EMR1_OPS),
        .EMR2_VAL(EMR2_VAL), .EMR3_VAL(EMR3_VAL)
    ) u_decode (
        .step(step_q), .bus(step_bus), .gap_kind(gap_kind)
    );

    ddr2i_wait_timer #(.W(GW)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
    );

    ddr2i_wait_timer #(.W(LW)) u_lock (
        .clk(clk), .rst(rst), .load(lock_load),
        .load_val(LW'(DLL_LOCK_CYC - 2)), .zero(lock_zero)
    );

    // an issued command at cycle c lets the next one out at c + gap
    always_comb begin
        gap_load = 1'b0;
        gap_val  = '0;
        case (phase_q)
            PH_IDLE: begin
                gap_load = pwr_ok;
                gap_val  = GW'(STABLE_CYC - 1);
            end
            PH_CLK_STABLE: begin
                gap_load = gap_zero;
                gap_val  = GW'(CKE_NOP_CYC - 1);
            end
            PH_ISSUE: begin
                gap_load = 1'b1;
                case (gap_kind)
                    GAP_PRECH: gap_val = GW'(TRP_CYC - 2);
                    GAP_REFR:  gap_val = GW'(TRFC_CYC - 2);
                    default:   gap_val = GW'(TMRD_CYC - 2);
                endcase
            end
            default: ;
        endcase
    end

    assign lock_load = (phase_q == PH_ISSUE) && (step_q == ST_MAIN_DLL_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_PREA_FIRST;
        end else begin
            case (phase_q)
                PH_IDLE:       if (pwr_ok) phase_q <= PH_CLK_STABLE;
                PH_CLK_STABLE: if (gap_zero) phase_q <= PH_CKE_WAIT;
                PH_CKE_WAIT: if (gap_zero) begin
                    phase_q <= PH_ISSUE;
                    step_q  <= ST_PREA_FIRST;
                end
                PH_ISSUE: phase_q <= PH_GAP;
                PH_GAP: if (gap_zero && (step_q != ST_MAIN_OPER || lock_zero)) begin
                    if (step_q == ST_EXT1_OCD_EXIT) begin
                        phase_q <= PH_READY;
                    end else begin
                        phase_q <= PH_ISSUE;
                        step_q  <= step_e'(step_q + 4'd1);
                    end
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    bus_t out_bus;
    always_comb begin
        out_bus.bank = '0;
        out_bus.addr = '0;
        out_bus.cmd  = CMD_NOP;
        if (phase_q == PH_IDLE || phase_q == PH_CLK_STABLE)
            out_bus.cmd = CMD_DESELECT;
        else if (phase_q == PH_ISSUE)
            out_bus = step_bus;
    end

    assign cke  = !(phase_q == PH_IDLE || phase_q == PH_CLK_STABLE);
    assign odt  = 1'b0;
    assign {cs_n, ras_n, cas_n, we_n} = out_bus.cmd;
    assign ba   = out_bus.bank;
    assign addr = out_bus.addr;
    assign done = (phase_q == PH_READY);

    logic [3:0] pin_cmd;
    assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

    // R2: clock enable never drops once raised
    a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);
    // R1: with clock enable low the device is deselected
    a_r1_deselect_low_cke: assert property (@(posedge clk) disable iff (rst)
        !cke |-> cs_n);
    // R8: each real command is followed by a no-operation cycle
    a_r8_single_cmd: assert property (@(posedge clk) disable iff (rst)
        (cke && pin_cmd != 4'b0111) |=> (pin_cmd == 4'b0111));
    // R9: OCD default only after the DLL lock window has elapsed
    a_r9_lock_before_ocd: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ISSUE && step_q == ST_EXT1_OCD_DEF) |-> lock_zero);
    // R10: ready is sticky and the bus stays idle
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (pin_cmd == 4'b0111 && cke));
    // R5: mode writes to MR never carry the top address bit
    a_r5_mr_top_clear: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == 4'b0000 && ba == 3'b000) |-> !addr[13]);

endmodule

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;
    localparam int S_CYC  = 20;
    localparam int C_CYC  = 5;
    localparam int MRD    = 2;
    localparam int RP     = 3;
    localparam int RFC    = 7;
    localparam int LOCK   = 30;
    localparam logic [13:0] MR_P   = 14'h2142;
    localparam logic [13:0] EMR1_P = 14'h2385;
    localparam logic [13:0] EMR2_P = 14'h0080;
    localparam logic [13:0] EMR3_P = 14'h0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0;
    logic cke, odt, cs_n, ras_n, cas_n, we_n, done;
    logic [2:0]  ba;
    logic [13:0] addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ddr2_init_seq #(
        .CLK_PS(4000), .STABLE_CYC(S_CYC), .CKE_NOP_CYC(C_CYC),
        .TMRD_CYC(MRD), .TRP_CYC(RP), .TRFC_CYC(RFC), .DLL_LOCK_CYC(LOCK),
        .MR_OPS(MR_P), .EMR1_OPS(EMR1_P), .EMR2_VAL(EMR2_P), .EMR3_VAL(EMR3_P)
    ) u_ddr2_init_seq (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .cke(cke), .odt(odt),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done)
    );

    int          exp_t[11];
    logic [3:0]  exp_c[11];
    logic [2:0]  exp_b[11];
    logic [13:0] exp_a[11];
    int          got_t[11];
    logic [3:0]  got_c[11];
    logic [2:0]  got_b[11];
    logic [13:0] got_a[11];

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int gap_after(input logic [3:0] c);
        if (c == 4'b0010) return RP;
        if (c == 4'b0001) return RFC;
        return MRD;
    endfunction

    task automatic build_expect();
        logic [13:0] mr_b, e1_b;
        mr_b = MR_P & ~14'h2100;
        e1_b = EMR1_P & ~14'h2381;
        exp_c = '{4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010,
                  4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000};
        exp_b = '{3'd0, 3'd2, 3'd3, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1};
        exp_a = '{14'h0400, EMR2_P, EMR3_P, e1_b, mr_b | 14'h0100, 14'h0400,
                  14'h0, 14'h0, mr_b, e1_b | 14'h0380, e1_b};
        exp_t[0] = S_CYC + 1 + C_CYC;
        for (int i = 1; i < 11; i++) exp_t[i] = exp_t[i-1] + gap_after(exp_c[i-1]);
        if (exp_t[4] + LOCK > exp_t[9]) exp_t[9] = exp_t[4] + LOCK;
        exp_t[10] = exp_t[9] + MRD;
    endtask

    task automatic idle_check(input string tag);
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk({tag, " R1 cke"}, cke, 0);
        chk({tag, " R1 done"}, done, 0);
        chk({tag, " R1 bus"}, {cs_n, ras_n, cas_n, we_n}, 4'b1111);
        chk({tag, " R12 odt"}, odt, 0);
    endtask

    // pwr_ok is raised at a falling edge; k counts falling edges after that
    task automatic run_full(input string tag, input int abort_at);
        int n_rec, cke_at, done_at, bad_pre, bad_post, odt_hi, k_last;
        n_rec = 0; cke_at = -1; done_at = -1;
        bad_pre = 0; bad_post = 0; odt_hi = 0;
        k_last = exp_t[10] + MRD + 10;
        pwr_ok = 1'b1;
        for (int k = 1; k <= k_last; k++) begin
            @(negedge clk);
            if (abort_at != 0 && k == abort_at) begin
                rst = 1'b1;
                pwr_ok = 1'b0;
                @(negedge clk);
                chk({tag, " R11 cke after reset"}, cke, 0);
                chk({tag, " R11 done after reset"}, done, 0);
                chk({tag, " R11 bus after reset"}, {cs_n, ras_n, cas_n, we_n}, 4'b1111);
                rst = 1'b0;
                return;
            end
            if (odt) odt_hi++;
            if (!cke) begin
                if ({cs_n, ras_n, cas_n, we_n} != 4'b1111) bad_pre++;
            end else begin
                if (cke_at < 0) cke_at = k;
                if (done) begin
                    if (done_at < 0) done_at = k;
                    if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) bad_post++;
                end else if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                    if (n_rec < 11) begin
                        got_t[n_rec] = k;
                        got_c[n_rec] = {cs_n, ras_n, cas_n, we_n};
                        got_b[n_rec] = ba;
                        got_a[n_rec] = addr;
                    end
                    n_rec++;
                end
            end
        end
        chk({tag, " R2 cke rise cycle"}, cke_at, S_CYC + 1);
        chk({tag, " R2 deselect before cke"}, bad_pre, 0);
        chk({tag, " R3 first command cycle"}, got_t[0] - cke_at, C_CYC);
        chk({tag, " R4 command count"}, n_rec, 11);
        for (int i = 0; i < 11; i++) begin
            chk($sformatf("%s R4 code #%0d", tag, i), got_c[i], exp_c[i]);
            chk($sformatf("%s R8 time #%0d", tag, i), got_t[i], exp_t[i]);
            if (exp_c[i] == 4'b0000) begin
                chk($sformatf("%s R5 bank #%0d", tag, i), got_b[i], exp_b[i]);
                chk($sformatf("%s R6 R7 R9 addr #%0d", tag, i), got_a[i], exp_a[i]);
            end
            if (exp_c[i] == 4'b0010)
                chk($sformatf("%s R3 all-bank bit #%0d", tag, i), got_a[i][10], 1);
        end
        chk({tag, " R9 ocd after lock"}, got_t[9] - got_t[4] >= LOCK, 1);
        chk({tag, " R10 done cycle"}, done_at, exp_t[10] + MRD);
        chk({tag, " R10 idle after done"}, bad_post, 0);
        chk({tag, " R12 odt"}, odt_hi, 0);
        pwr_ok = 1'b0;
    endtask

    initial begin
        build_expect();
        @(negedge clk);
        chk("R1 cke in reset", cke, 0);
        chk("R1 done in reset", done, 0);
        @(negedge clk);
        rst = 1'b0;
        idle_check("first");
        run_full("run1", 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_check("second");
        run_full("cut", exp_t[6]);
        idle_check("after cut");
        run_full("run2", 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule